// File: doc/BRIEF.md
# Black Level Servo Loop

This block holds the black level of an image sensor's digitised signal at a programmed target. During a window pulse placed over the shielded, light-blocked pixels at the start of each line, the block compares each ADC sample with an 8-bit target. It sums the differences and, when the window closes, turns the sum into a filtered correction. The correction is a saturating code for an offset DAC that sits in front of the ADC. When the corrected level sits above the target the code falls, and when it sits below the target the code rises.

A line sync input sets the update pacing. By default every line may update the correction. A divider value N restricts updates to one line in every N. With the loop enable low, the correction register is frozen and the DAC is driven directly with the target value as a static, programmable offset. The pixel rate is the block clock, and one sample arrives on every cycle.

Top module: `blc_clamp_loop`

## Requirements
- R1: On reset the correction register is mid-scale (512 for the default 10-bit DAC), and with the loop enabled the DAC output shows that value.
- R2: Only samples taken while the window input is high enter the error sum. Samples outside the window have no effect on the DAC output.
- R3: Each window sample adds the signed error, sample minus zero-extended target, to a sum. When the window closes (high on the previous cycle, low now), the step is the sum arithmetically shifted right by 5 (the averaging shift) and then by 2 (the loop gain shift). The step is subtracted from the correction on the next clock edge.
- R4: A 4-bit line divider N sets a line phase that advances on each rising edge of the line sync input and returns to 0 after reaching N-1. A correction is applied at a window close only while the phase is 0. N values of 0 and 1 both mean every line.
- R5: The correction saturates at 0 and at 1023 and never wraps.
- R6: With the loop enable low, the DAC output equals the zero-extended target, and the correction register keeps its value. The loop resumes from that value once it is enabled again.
- R7: The correction register changes only on the clock edge at a window close.
- R8: The error sum restarts at the first sample of every window, so no error carries over from an earlier line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 12 | ADC sample, unsigned |
| clamp_win_i | input | 1 | High over the shielded black pixels |
| line_sync_i | input | 1 | Line sync pulse; its rising edge advances the line phase |
| target_i | input | 8 | Black level target in LSB |
| loop_en_i | input | 1 | 1 runs the loop, 0 gives the static offset |
| line_div_i | input | 4 | Update divider N (0 or 1 means every line) |
| dac_code_o | output | 10 | Offset DAC code |

## Verification
On every cycle, the assertions check that the correction moves only on a window-closing edge. They also check that it holds on non-update lines and while the loop is disabled, that a non-negative error sum can never raise it, and that it stays pinned at full scale when the sum would push it higher. They cannot show the exact size of the step, the averaging with floor rounding, the phase pattern of the divider, or resumption after a bypass period. The bench shows these with directed lines at known errors, long runs into both saturation limits, and randomised lines with random targets, noise, window lengths and divider values.

// File: rtl/blc_pkg.sv
package blc_pkg;
  localparam int SAMPLE_W_D = 12;
  localparam int TARGET_W_D = 8;
  localparam int DAC_W_D    = 10;
  localparam int WIN_LG_D   = 8;   // window up to 2**WIN_LG_D samples
  localparam int AVG_SH_D   = 5;   // averaging shift
  localparam int GAIN_SH_D  = 2;   // loop gain shift
  localparam int DIV_W_D    = 4;
endpackage

// File: rtl/blc_err_accum.sv
module blc_err_accum #(
  parameter int SAMPLE_W = 12,
  parameter int TARGET_W = 8,
  parameter int SUM_W    = 21
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    win_i,
  input  logic [SAMPLE_W-1:0]     sample_i,
  input  logic [TARGET_W-1:0]     target_i,
  output logic signed [SUM_W-1:0] sum_o,
  output logic                    close_o
);
  logic                    win_q;
  logic signed [SUM_W-1:0] sum_q, sum_d, err;
  logic                    sum_en;

  always_comb begin
    err    = signed'({{(SUM_W-SAMPLE_W){1'b0}}, sample_i})
           - signed'({{(SUM_W-TARGET_W){1'b0}}, target_i});
    sum_en = win_i;
    // first sample of a window restarts the sum
    sum_d  = win_q ? (sum_q + err) : err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      sum_q <= '0;
    end else begin
      win_q <= win_i;
      if (sum_en) sum_q <= sum_d;
    end
  end

  assign sum_o   = sum_q;
  assign close_o = win_q & ~win_i;
endmodule

// File: rtl/blc_line_pacer.sv
module blc_line_pacer #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             upd_line_o
);
  logic             sync_q;
  logic [DIV_W-1:0] phase_q, phase_d, last;
  logic             rise;

  always_comb begin
    last    = (div_i <= DIV_W'(1)) ? '0 : div_i - DIV_W'(1);
    rise    = sync_i & ~sync_q;
    phase_d = (phase_q >= last) ? '0 : phase_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      phase_q <= '0;
    end else begin
      sync_q <= sync_i;
      if (rise) phase_q <= phase_d;
    end
  end

  assign upd_line_o = (phase_q == '0);
endmodule

// File: rtl/blc_corr_update.sv
module blc_corr_update #(
  parameter int DAC_W   = 10,
  parameter int SUM_W   = 21,
  parameter int AVG_SH  = 5,
  parameter int GAIN_SH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    apply_i,
  input  logic signed [SUM_W-1:0] sum_i,
  output logic [DAC_W-1:0]        corr_o
);
  localparam int EXT_W = ((SUM_W > DAC_W) ? SUM_W : DAC_W) + 2;
  localparam logic [DAC_W-1:0] MID = DAC_W'(1) << (DAC_W-1);
  localparam logic signed [EXT_W-1:0] TOP = EXT_W'((64'd1 << DAC_W) - 64'd1);

  logic [DAC_W-1:0]        corr_q, corr_d;
  logic signed [SUM_W-1:0] avg, step;
  logic signed [EXT_W-1:0] step_x, corr_x, diff;

  always_comb begin
    avg    = sum_i >>> AVG_SH;
    step   = avg >>> GAIN_SH;
    step_x = EXT_W'(step);
    corr_x = signed'({{(EXT_W-DAC_W){1'b0}}, corr_q});
    diff   = corr_x - step_x;
    if (diff < 0)        corr_d = '0;
    else if (diff > TOP) corr_d = TOP[DAC_W-1:0];
    else                 corr_d = diff[DAC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       corr_q <= MID;
    else if (apply_i) corr_q <= corr_d;
  end

  assign corr_o = corr_q;
endmodule

// File: rtl/blc_clamp_loop.sv
module blc_clamp_loop #(
  parameter int SAMPLE_W = blc_pkg::SAMPLE_W_D,
  parameter int TARGET_W = blc_pkg::TARGET_W_D,
  parameter int DAC_W    = blc_pkg::DAC_W_D,
  parameter int WIN_LG   = blc_pkg::WIN_LG_D,
  parameter int AVG_SH   = blc_pkg::AVG_SH_D,
  parameter int GAIN_SH  = blc_pkg::GAIN_SH_D,
  parameter int DIV_W    = blc_pkg::DIV_W_D
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                clamp_win_i,
  input  logic                line_sync_i,
  input  logic [TARGET_W-1:0] target_i,
  input  logic                loop_en_i,
  input  logic [DIV_W-1:0]    line_div_i,
  output logic [DAC_W-1:0]    dac_code_o
);
  localparam int SUM_W = SAMPLE_W + 1 + WIN_LG;

  logic signed [SUM_W-1:0] err_sum;
  logic                    win_close, upd_line, apply;
  logic [DAC_W-1:0]        corr_q;

  blc_err_accum #(.SAMPLE_W(SAMPLE_W), .TARGET_W(TARGET_W), .SUM_W(SUM_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .win_i(clamp_win_i), .sample_i(sample_i),
    .target_i(target_i), .sum_o(err_sum), .close_o(win_close));

  blc_line_pacer #(.DIV_W(DIV_W)) u_pace (
    .clk(clk), .rst_n(rst_n), .sync_i(line_sync_i), .div_i(line_div_i),
    .upd_line_o(upd_line));

  assign apply = win_close & loop_en_i & upd_line;

  blc_corr_update #(.DAC_W(DAC_W), .SUM_W(SUM_W), .AVG_SH(AVG_SH), .GAIN_SH(GAIN_SH)) u_corr (
    .clk(clk), .rst_n(rst_n), .apply_i(apply), .sum_i(err_sum), .corr_o(corr_q));

  assign dac_code_o = loop_en_i ? corr_q : {{(DAC_W-TARGET_W){1'b0}}, target_i};
endmodule

// File: rtl/blc_clamp_checker.sv
module blc_clamp_checker #(
  parameter int DAC_W = 10,
  parameter int SUM_W = 21
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    loop_en,
  input logic                    close,
  input logic                    upd_line,
  input logic signed [SUM_W-1:0] sum,
  input logic [DAC_W-1:0]        corr
);
  localparam logic [DAC_W-1:0] MID = DAC_W'(1) << (DAC_W-1);
  localparam logic [DAC_W-1:0] FULL = '1;

  // R1
  a_r1_reset_mid: assert property (@(posedge clk) $rose(rst_n) |-> corr == MID);
  // R7
  a_r7_only_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    !close |=> $stable(corr));
  // R6
  a_r6_frozen_off: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |=> $stable(corr));
  // R4
  a_r4_skip_line: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_line |=> $stable(corr));
  // R3
  a_r3_direction: assert property (@(posedge clk) disable iff (!rst_n)
    (close && sum >= 0) |=> corr <= $past(corr));
  // R5
  a_r5_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    (corr == FULL && sum < 0) |=> corr == FULL);
endmodule

bind blc_clamp_loop blc_clamp_checker #(.DAC_W(DAC_W), .SUM_W(SUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .loop_en(loop_en_i), .close(win_close),
  .upd_line(upd_line), .sum(err_sum), .corr(corr_q));

// File: tb/tb_blc_clamp_loop.sv
module tb_blc_clamp_loop;
  logic        clk, rst_n, win, hd, en;
  logic [11:0] smp;
  logic [7:0]  tgt;
  logic [3:0]  div;
  logic [9:0]  dac;

  int checks = 0, errors = 0;
  int m_corr, m_sum, m_phase;
  bit m_winq, m_hdq;

  blc_clamp_loop dut (.clk(clk), .rst_n(rst_n), .sample_i(smp), .clamp_win_i(win),
    .line_sync_i(hd), .target_i(tgt), .loop_en_i(en), .line_div_i(div), .dac_code_o(dac));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat(int v);
    if (v < 0) return 0;
    if (v > 1023) return 1023;
    return v;
  endfunction

  function automatic int expect_dac();
    return en ? m_corr : int'(tgt);
  endfunction

  task automatic model_edge();
    int last;
    last = (div <= 1) ? 0 : int'(div) - 1;
    if (m_winq && !win && en && m_phase == 0)
      m_corr = sat(m_corr - ((m_sum >>> 5) >>> 2));
    if (win) m_sum = m_winq ? m_sum + int'(smp) - int'(tgt) : int'(smp) - int'(tgt);
    if (hd && !m_hdq) m_phase = (m_phase >= last) ? 0 : m_phase + 1;
    m_winq = win;
    m_hdq  = hd;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic line(int wlen, int base, int noise, string req);
    hd = 1'b1; win = 1'b0; smp = 12'($urandom_range(0, 4095));
    cyc(); cyc();
    hd = 1'b0;
    repeat (3) begin smp = 12'($urandom_range(0, 4095)); cyc(); end
    for (int i = 0; i < wlen; i++) begin
      int v;
      v = base + int'($urandom_range(0, 2*noise)) - noise;
      smp = 12'((v < 0) ? 0 : (v > 4095) ? 4095 : v);
      win = 1'b1;
      cyc();
    end
    win = 1'b0;
    repeat (3) begin smp = 12'($urandom_range(0, 4095)); cyc(); end
    chk(req, int'(dac), expect_dac());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int prev;
    void'($urandom(32'd1234));
    rst_n = 1'b0; win = 1'b0; hd = 1'b0; en = 1'b1; smp = '0; tgt = 8'd64; div = 4'd1;
    m_corr = 512; m_sum = 0; m_phase = 0; m_winq = 0; m_hdq = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset", int'(dac), 512);
    rst_n = 1'b1;
    cyc();
    chk("R1 after release", int'(dac), 512);

    // R3: error +40 over 32 pixels -> step 10
    line(32, 104, 0, "R3 above target");
    chk("R3 step down", int'(dac), 502);
    // R3: target 200, samples 100 -> step -25
    tgt = 8'd200;
    line(32, 100, 0, "R3 below target");
    chk("R3 step up", int'(dac), 527);
    // R2: window samples equal target, random outside
    prev = int'(dac);
    line(40, 200, 0, "R2 outside ignored");
    chk("R2 unchanged", int'(dac), prev);
    // R4: every third line
    div = 4'd3;
    for (int k = 0; k < 6; k++) line(32, 260, 0, "R4 divider 3");
    div = 4'd0;
    for (int k = 0; k < 3; k++) line(32, 180, 0, "R4 divider 0");
    // R8: large error on skipped line, zero error on update line
    div = 4'd2;
    for (int k = 0; k < 4; k++) line(32, (m_phase == 1) ? 200 : 1200, 0, "R8 restart");
    div = 4'd1;
    // R5: saturate low then high
    tgt = 8'd255;
    for (int k = 0; k < 3; k++) line(32, 4095, 0, "R5 low saturation");
    chk("R5 floor", int'(dac), 0);
    for (int k = 0; k < 20; k++) line(32, 0, 0, "R5 high saturation");
    chk("R5 ceiling", int'(dac), 1023);
    // R6: bypass
    prev = int'(dac);
    en = 1'b0; tgt = 8'd37;
    line(32, 3000, 0, "R6 bypass");
    chk("R6 static offset", int'(dac), 37);
    line(32, 10, 0, "R6 bypass");
    en = 1'b1;
    cyc();
    chk("R6 resume", int'(dac), prev);
    // random lines
    for (int k = 0; k < 80; k++) begin
      tgt = 8'($urandom_range(0, 255));
      div = 4'($urandom_range(0, 4));
      en  = ($urandom_range(0, 9) != 0);
      line(int'($urandom_range(20, 60)), int'($urandom_range(0, 600)),
           int'($urandom_range(0, 40)), "R3 R4 R6 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule